// File: doc/BRIEF.md
# Receive VLAN Tag Filter and Stripper

This block sits on a receive byte stream between the MAC and the descriptor logic. It looks at bytes 12 and 13 of every frame, and when they match a programmable tag type it treats bytes 14 and 15 as a tag control word. The low bits of that word form the VLAN ID, which selects one bit of a membership bitmap. With filtering enabled, a tagged frame whose bit is clear is marked as dropped. With stripping enabled, the four tag bytes are cut out of the stream. The twelve address bytes go out first, followed directly by the payload. The removed control word and a "tag present" flag are reported once per frame.

Software loads the bitmap one 32-bit word at a time through a plain write-strobe, address and data port, and can read any word back combinationally. Every byte passes through a fixed four-stage delay line. The tag can therefore be removed without stalling the input, and a per-frame decision strobe fires in the cycle after byte 15 is taken. For frames shorter than 16 bytes, it fires in the cycle after the last byte.

Top module: `rx_tag_filter`

## Requirements
- R1: After reset, out_valid and dec_valid are low and every membership word reads as zero.
- R2: A write with cfg_wr high stores cfg_wdata in word cfg_addr, and cfg_rdata shows word cfg_addr combinationally from the next cycle onward, for any address 0 to 127.
- R3: A frame is tagged only when byte 12 (high) and byte 13 (low), taken big-endian, equal tag_type; a frame carrying another type value is treated as untagged.
- R4: The VLAN ID is bits 11:0 of the control word {byte 14, byte 15}; its membership bit is bit ID[4:0] of word ID[11:5].
- R5: With filt_en high, a tagged frame whose membership bit is 0 gets dec_accept = 0, and one whose bit is 1 gets dec_accept = 1.
- R6: Untagged frames, and tagged frames with filt_en low, get dec_accept = 1; untagged frames also get dec_vlan = 0 and dec_tci = 0.
- R7: With strip_en high, a tagged frame leaves with bytes 12 to 15 removed, so it is 4 bytes shorter and keeps bytes 0 to 11 ahead of byte 16 onward; otherwise the frame leaves unchanged.
- R8: A stripped frame reports dec_vlan = 1 and dec_tci = {byte 14, byte 15}; a frame that is not stripped reports dec_vlan = 0 and dec_tci = 0.
- R9: dec_valid pulses for exactly one cycle per frame. The pulse comes in the cycle after byte 15 is accepted, or in the cycle after the end byte when the frame is shorter than 16 bytes.
- R10: Each byte that is kept appears on the output 4 cycles after it is accepted, with its start and end markers intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| tag_type | input | 16 | Type value that marks a tagged frame |
| filt_en | input | 1 | Enable membership filtering |
| strip_en | input | 1 | Enable tag removal |
| cfg_wr | input | 1 | Membership word write strobe |
| cfg_addr | input | 7 | Membership word index |
| cfg_wdata | input | 32 | Membership word write data |
| cfg_rdata | output | 32 | Membership word at cfg_addr |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_data | output | 8 | Output byte |
| dec_valid | output | 1 | Per-frame decision strobe |
| dec_accept | output | 1 | Frame accepted (1) or dropped (0) |
| dec_vlan | output | 1 | Tag was removed from this frame |
| dec_tci | output | 16 | Removed tag control word, else zero |

## Verification
The bench builds the block with its default parameters: a 12-bit VLAN ID over 32-bit words, giving 128 words. This puts the extreme table positions within reach: word 0, and word 127 bit 31 for ID 0xFFF. A neighbouring-bit case shows that the word and bit split is exact. The tag type is changed during the run, so matching against a fixed value would be caught. Frames longer and shorter than the 16-byte header are sent, which shows the strobe timing on both paths and the byte order after the cut.

// File: rtl/rtv_pkg.sv
// Shared types and fixed frame offsets for the receive VLAN tag filter.
// Assumes an Ethernet layout: 12 address bytes, then type, then control word.
package rtv_pkg;
    localparam int TAG_BYTES = 4;   // bytes removed when stripping
    localparam int TYPE_OFS  = 12;  // first byte of the type field
    localparam int HDR_LAST  = 15;  // last byte of the tag

    typedef struct packed {
        logic       v;
        logic       sof;
        logic       eof;
        logic [7:0] d;
    } lane_t;
endpackage

// File: rtl/vid_member_table.sv
// VLAN membership bitmap held in flops, one bit per VLAN ID.
// Software side: one-cycle write, combinational read.
// Lookup side: combinational bit select from the ID.
// Assumes VID_W >= log2(WORD_W).
module vid_member_table #(
    parameter int VID_W  = 12,
    parameter int WORD_W = 32,
    localparam int NWORDS = (1 << VID_W) / WORD_W,
    localparam int AW     = $clog2(NWORDS),
    localparam int BW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [VID_W-1:0]  vid,
    output logic              member
);
    logic [WORD_W-1:0] mem [NWORDS];

    // Clear the table on reset, store software writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (wr) begin
            mem[addr] <= wdata;
        end
    end

    // Software read port.
    assign rdata = mem[addr];

    // Lookup: upper ID bits choose the word, lower ID bits the bit.
    assign member = mem[vid[VID_W-1:BW]][vid[BW-1:0]];

    // R2: a write is visible on the read port in the next cycle at the same address.
    p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && addr == $past(addr)) |-> rdata == $past(wdata));
endmodule

// File: rtl/tag_delay_line.sv
// Fixed-latency byte delay line, TAG_BYTES stages deep. A kill pulse on the
// cycle the last tag byte arrives empties every stage. At that moment the
// stages hold exactly the tag bytes, so those bytes never leave.
// Assumes header bytes 12..15 arrive on consecutive cycles.
module tag_delay_line
    import rtv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t in_lane,
    input  logic  kill,
    output lane_t out_lane
);
    localparam int DEPTH = TAG_BYTES;

    lane_t st [DEPTH];

    // First stage: take the incoming byte, or nothing when killed.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) st[0] <= '0;
        else                st[0] <= in_lane.v ? in_lane : '0;
    end

    // Remaining stages shift every cycle; a kill drops what would move in.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || kill) st[g] <= '0;
            else                st[g] <= st[g-1];
        end
    end

    assign out_lane = st[DEPTH-1];

    // R7: a kill leaves the first stage empty in the following cycle.
    p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(kill) |-> !st[0].v);
endmodule

// File: rtl/tag_parser.sv
// Counts bytes in each frame, captures the type and control word, and issues
// a one-cycle decision strobe. The strobe fires after byte 15, or after the
// end byte of a frame shorter than the tag header. It also drives the table
// lookup ID and the kill pulse for the delay line.
module tag_parser
    import rtv_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic [15:0]      tag_type,
    input  logic             filt_en,
    input  logic             strip_en,
    input  logic             member,
    output logic [VID_W-1:0] lookup_vid,
    output logic             kill,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_vlan,
    output logic [15:0]      dec_tci
);
    localparam logic [4:0] I_TYPE_HI = 5'(TYPE_OFS);
    localparam logic [4:0] I_TYPE_LO = 5'(TYPE_OFS + 1);
    localparam logic [4:0] I_TCI_HI  = 5'(TYPE_OFS + 2);
    localparam logic [4:0] I_LAST    = 5'(HDR_LAST);
    localparam logic [4:0] I_SAT     = 5'(HDR_LAST + 1);

    logic [4:0]  idx, cur_idx;
    logic [7:0]  type_hi, type_lo, tci_hi;
    logic [15:0] tci_now;
    logic        at_last, hit, short_end;

    // Position of the current byte; a start marker forces index 0.
    assign cur_idx    = in_sof ? 5'd0 : idx;
    assign at_last    = in_valid && cur_idx == I_LAST;
    assign short_end  = in_valid && in_eof && cur_idx < I_LAST;
    assign tci_now    = {tci_hi, in_data};
    assign hit        = {type_hi, type_lo} == tag_type;
    assign lookup_vid = tci_now[VID_W-1:0];
    assign kill       = at_last && hit && strip_en;

    // Byte counter and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            type_hi <= '0;
            type_lo <= '0;
            tci_hi  <= '0;
        end else if (in_valid) begin
            idx <= (cur_idx == I_SAT) ? cur_idx : cur_idx + 5'd1;
            if (cur_idx == I_TYPE_HI) type_hi <= in_data;
            if (cur_idx == I_TYPE_LO) type_lo <= in_data;
            if (cur_idx == I_TCI_HI)  tci_hi  <= in_data;
        end
    end

    // Per-frame decision register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_vlan   <= 1'b0;
            dec_tci    <= '0;
        end else begin
            dec_valid <= at_last || short_end;
            if (at_last) begin
                dec_accept <= !(hit && filt_en && !member);
                dec_vlan   <= hit && strip_en;
                dec_tci    <= (hit && strip_en) ? tci_now : 16'h0;
            end else if (short_end) begin
                dec_accept <= 1'b1;
                dec_vlan   <= 1'b0;
                dec_tci    <= 16'h0;
            end
        end
    end

    // R5: a drop is only ever reported when filtering was enabled.
    p_drop_needs_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> $past(filt_en));
    // R7: a reported strip only happens when stripping was enabled.
    p_strip_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_vlan) |-> $past(strip_en));
    // R8: the control word reads zero whenever no tag was removed.
    p_tci_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_vlan) |-> dec_tci == 16'h0);
endmodule

// File: rtl/rx_tag_filter.sv
// Receive VLAN tag filter and stripper. It wires the header parser, the
// membership table and the four-stage delay line together.
// Assumes no backpressure, header bytes 12..15 on consecutive cycles, and
// tagged frames longer than 16 bytes.
module rx_tag_filter
    import rtv_pkg::*;
#(
    parameter int VID_W  = 12,
    parameter int WORD_W = 32,
    localparam int NWORDS = (1 << VID_W) / WORD_W,
    localparam int AW     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [15:0]       tag_type,
    input  logic              filt_en,
    input  logic              strip_en,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [7:0]        out_data,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_vlan,
    output logic [15:0]       dec_tci
);
    logic [VID_W-1:0] vid;
    logic             member, kill;
    lane_t            in_lane, out_lane;

    assign in_lane = '{v: in_valid, sof: in_sof, eof: in_eof, d: in_data};

    tag_parser #(.VID_W(VID_W)) u_parser (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .tag_type(tag_type), .filt_en(filt_en), .strip_en(strip_en),
        .member(member), .lookup_vid(vid), .kill(kill),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_vlan(dec_vlan), .dec_tci(dec_tci)
    );

    vid_member_table #(.VID_W(VID_W), .WORD_W(WORD_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .vid(vid), .member(member)
    );

    tag_delay_line u_delay (
        .clk(clk), .rst_n(rst_n),
        .in_lane(in_lane), .kill(kill), .out_lane(out_lane)
    );

    assign out_valid = out_lane.v;
    assign out_sof   = out_lane.sof;
    assign out_eof   = out_lane.eof;
    assign out_data  = out_lane.d;
endmodule

// File: tb/tb_rx_tag_filter.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_rx_tag_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic [15:0] tag_type = 16'h8100;
    logic        filt_en = 1'b0, strip_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_addr = 7'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic        dec_valid, dec_accept, dec_vlan;
    logic [15:0] dec_tci;

    rx_tag_filter dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    logic [7:0] fb [0:63];
    logic [7:0] obuf [0:63];
    int ocnt, osof_cyc, dcnt, d_cyc, drv_dec_cyc, drv_sof_cyc;
    bit oeof_seen, d_acc, d_vlan;
    logic [15:0] d_tci;

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (out_sof) begin ocnt = 0; osof_cyc = cyc; end
            if (ocnt < 64) obuf[ocnt] = out_data;
            ocnt++;
            if (out_eof) oeof_seen = 1;
        end
        if (dec_valid) begin
            dcnt++; d_cyc = cyc; d_acc = dec_accept; d_vlan = dec_vlan; d_tci = dec_tci;
        end
    end

    task automatic chk(string rq, bit ok, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic build(int len, logic [15:0] ty, logic [15:0] tci, int seed);
        for (int i = 0; i < 64; i++) fb[i] = 8'((i * 7 + seed) & 8'hff);
        fb[12] = ty[15:8]; fb[13] = ty[7:0]; fb[14] = tci[15:8]; fb[15] = tci[7:0];
        if (len < 64) for (int i = len; i < 64; i++) fb[i] = 8'h00;
    endtask

    task automatic send(int len);
        ocnt = 0; dcnt = 0; oeof_seen = 0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = fb[i];
            if (i == 0) drv_sof_cyc = cyc;
            if (i == 15 || (len < 16 && i == len - 1)) drv_dec_cyc = cyc;
        end
        @(posedge clk); #1;
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (8) @(posedge clk);
        #1;
    endtask

    // Compare the captured frame and decision against values from the requirements.
    task automatic check_frame(string rq, int len, bit stripped, bit e_acc, bit e_vlan,
                               logic [15:0] e_tci);
        int elen = stripped ? len - 4 : len;
        int bad = 0;
        for (int i = 0; i < elen; i++) begin
            int src = (stripped && i >= 12) ? i + 4 : i;
            if (obuf[i] !== fb[src]) bad++;
        end
        chk({rq, " length"}, ocnt == elen, ocnt, elen);
        chk({rq, " bytes"}, bad == 0, bad, 0);
        chk({rq, " eof R10"}, oeof_seen, oeof_seen, 1);
        chk({rq, " latency R10"}, osof_cyc == drv_sof_cyc + 4, osof_cyc, drv_sof_cyc + 4);
        chk({rq, " one strobe R9"}, dcnt == 1, dcnt, 1);
        chk({rq, " strobe cycle R9"}, d_cyc == drv_dec_cyc + 1, d_cyc, drv_dec_cyc + 1);
        chk({rq, " accept"}, d_acc == e_acc, d_acc, e_acc);
        chk({rq, " vlan"}, d_vlan == e_vlan, d_vlan, e_vlan);
        chk({rq, " tci"}, d_tci == e_tci, d_tci, e_tci);
    endtask

    task automatic cfg_write(int a, logic [31:0] v);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_addr = 7'(a); cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic cfg_check(string rq, int a, logic [31:0] v);
        cfg_addr = 7'(a); #1;
        chk(rq, cfg_rdata === v, cfg_rdata, v);
    endtask

    task automatic t_reset;
        chk("R1 out_valid", out_valid === 1'b0, out_valid, 0);
        chk("R1 dec_valid", dec_valid === 1'b0, dec_valid, 0);
        cfg_check("R1 word 0", 0, 32'h0);
        cfg_check("R1 word 127", 127, 32'h0);
    endtask

    task automatic t_regs;
        cfg_write(0, 32'hA5A5_5A5A);
        cfg_write(127, 32'h8000_0001);
        cfg_write(64, 32'h1234_5678);
        cfg_check("R2 word 0", 0, 32'hA5A5_5A5A);
        cfg_check("R2 word 127", 127, 32'h8000_0001);
        cfg_check("R2 word 64", 64, 32'h1234_5678);
        cfg_write(0, 0); cfg_write(127, 0); cfg_write(64, 0);
        cfg_check("R2 cleared", 127, 32'h0);
    endtask

    task automatic t_untagged;
        tag_type = 16'h8100; filt_en = 1; strip_en = 1;
        build(24, 16'h0800, 16'h0123, 3);
        send(24);
        check_frame("R6 untagged", 24, 0, 1, 0, 16'h0);
    endtask

    task automatic t_filter;
        tag_type = 16'h8100; filt_en = 1; strip_en = 0;
        build(30, 16'h8100, 16'h0123, 5);
        send(30);
        check_frame("R5 drop empty table", 30, 0, 0, 0, 16'h0);
        cfg_write(9, 32'h0000_0010);                 // R4 neighbour bit of ID 0x123
        send(30);
        check_frame("R4 neighbour bit drops", 30, 0, 0, 0, 16'h0);
        cfg_write(9, 32'h0000_0008);                 // R4 word 9 bit 3 = ID 0x123
        send(30);
        check_frame("R5 member passes", 30, 0, 1, 0, 16'h0);
        cfg_write(127, 32'h8000_0000);               // R4 ID 0xFFF, top bit
        build(20, 16'h8100, 16'h5FFF, 9);
        send(20);
        check_frame("R4 id FFF passes", 20, 0, 1, 0, 16'h0);
        cfg_write(127, 0);
    endtask

    task automatic t_filter_off;
        tag_type = 16'h8100; filt_en = 0; strip_en = 0;
        build(22, 16'h8100, 16'h0456, 11);
        send(22);
        check_frame("R6 filter off accepts", 22, 0, 1, 0, 16'h0);
    endtask

    task automatic t_strip;
        tag_type = 16'h8100; filt_en = 1; strip_en = 1;
        build(28, 16'h8100, 16'hA123, 13);
        send(28);
        check_frame("R7 R8 strip member", 28, 1, 1, 1, 16'hA123);
        build(40, 16'h8100, 16'h0777, 17);           // ID 0x777 not a member
        send(40);
        check_frame("R7 R8 strip and drop", 40, 1, 0, 1, 16'h0777);
    endtask

    task automatic t_tagtype;
        tag_type = 16'h88A8; filt_en = 1; strip_en = 1;
        build(26, 16'h8100, 16'h0777, 19);
        send(26);
        check_frame("R3 other type untagged", 26, 0, 1, 0, 16'h0);
        build(26, 16'h88A8, 16'h2123, 21);
        send(26);
        check_frame("R3 programmed type strips", 26, 1, 1, 1, 16'h2123);
        tag_type = 16'h8100;
    endtask

    task automatic t_short;
        filt_en = 1; strip_en = 1;
        build(10, 16'h0000, 16'h0000, 23);
        send(10);
        check_frame("R9 short frame", 10, 0, 1, 0, 16'h0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_regs();
        t_untagged();
        t_filter();
        t_filter_off();
        t_strip();
        t_tagtype();
        t_short();
        finish_run();
    end
endmodule